// File: doc/BRIEF.md
# Password-Gated Memory Access Guard

This block decides, for every access aimed at the protected memories of a chip, whether that access may proceed. A single instance covers the non-volatile code store, the one-time-programmable area and two on-chip RAM blocks together. The requester only has to say whether the target lies in that protected set. The guard holds a lock flag that starts set. The flag clears only after software has loaded a 128-bit key into eight 16-bit key words, and that key equals the password read from non-volatile storage in every bit.

While locked, the guard refuses protected accesses that come from the debug port, from code running out of external memory, or from any other untrusted source. Code executing from on-chip memory is always served. The stored password is presented on a 128-bit input. Two patterns of that input have a special meaning. A password of all ones marks a blank, unsecured part, which leaves reset unlocked. A password of all zeros marks a part that is sealed for good, and no key can open it.

The access interface has no back-pressure. A request is a plain `acc_valid` qualifier with its source and target. The guard never stalls, and it answers in the same cycle on `acc_allow`. The key port is a plain write strobe with a word index. Status is three level outputs.

Top module: `pwg_top`

## Requirements
- R1: With reset asserted, on the next clock the lock flag becomes unlocked if the password is all ones and locked otherwise. All eight key words are cleared to zero.
- R2: A key write to any word index 0 to 6 stores that word and leaves the lock flag unchanged on the next cycle.
- R3: A key write to index 7 compares all eight words, with the incoming word standing in for word 7. Key word i is matched against password bits [16i+15:16i]. If every bit is equal, `unlocked_o` reads 1 from the next clock.
- R4: A key write to index 7 whose resulting key differs from the password in any bit sets the flag to locked on the next clock, even if the guard was unlocked.
- R5: `force_lock` high sets the flag to locked on the next clock. It wins over a key write to index 7 in the same cycle.
- R6: When the password is all zeros, `perm_lock_o` is 1 and the flag never reads unlocked, even after a key of all zeros is loaded.
- R7: A valid access with source code 0 (on-chip code execution) is allowed in the same cycle, whatever the lock state.
- R8: A valid protected access with source code 1 (debug port), 2 (external-memory code) or 3 (other) is denied while locked and allowed while unlocked, in the same cycle.
- R9: A valid access with `acc_prot` low is allowed from any source.
- R10: `acc_allow` is 0 whenever `acc_valid` is 0.
- R11: `blank_o` is 1 exactly when the password is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pw_i | input | 128 | Stored password; word i on bits [16i+15:16i] |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 3 | Key word index; 7 triggers the comparison |
| key_data | input | 16 | Key word value |
| force_lock | input | 1 | Return to locked on the next clock |
| acc_valid | input | 1 | Access request present this cycle |
| acc_src | input | 2 | Source: 0 on-chip code, 1 debug, 2 external code, 3 other |
| acc_prot | input | 1 | Access targets a protected region |
| acc_allow | output | 1 | Access may proceed (same cycle) |
| unlocked_o | output | 1 | Guard is unlocked |
| perm_lock_o | output | 1 | Password is all zeros; sealed |
| blank_o | output | 1 | Password is all ones; unsecured part |

## Verification
The timing differs by result. `acc_allow`, `perm_lock_o` and `blank_o` respond in the same cycle as their inputs. The lock flag moves exactly one clock after the key write, `force_lock` pulse or reset edge that causes it. The reference model follows the same split. Inputs are driven just after the falling edge. All four outputs are compared a few nanoseconds later against the model's state for that cycle. The model updates its lock state only at the following rising edge. A one-cycle-early or one-cycle-late flag change therefore shows up as a mismatch.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    SRC_ONCHIP = 2'd0,
    SRC_DEBUG  = 2'd1,
    SRC_EXTMEM = 2'd2,
    SRC_OTHER  = 2'd3
  } src_e;
endpackage

// File: rtl/pwg_keyreg.sv
module pwg_keyreg #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int KEY_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [KEY_W-1:0]  key_view,
  output logic              commit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  assign commit = wr_en && (wr_idx == LAST_IDX);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end
    // forward the word being written so the comparison sees the new key
    assign key_view[i*WORD_W +: WORD_W] = hit ? wr_data : word_q;
  end
endmodule

// File: rtl/pwg_compare.sv
module pwg_compare #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  localparam int KEY_W    = WORD_W * NUM_WORDS
) (
  input  logic [KEY_W-1:0] pw,
  input  logic [KEY_W-1:0] key,
  output logic             match,
  output logic             pw_zero,
  output logic             pw_ones
);
  logic [NUM_WORDS-1:0] word_eq;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_eq
    assign word_eq[i] = (pw[i*WORD_W +: WORD_W] == key[i*WORD_W +: WORD_W]);
  end

  assign match   = &word_eq;
  assign pw_zero = ~|pw;
  assign pw_ones = &pw;
endmodule

// File: rtl/pwg_lockfsm.sv
module pwg_lockfsm (
  input  logic clk,
  input  logic rst_n,
  input  logic blank,
  input  logic sealed,
  input  logic commit,
  input  logic match,
  input  logic force_lock,
  output logic unlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n)          unlocked <= blank && !sealed;
    else if (force_lock) unlocked <= 1'b0;
    else if (commit)     unlocked <= match && !sealed;
  end

  AST_SEALED_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !unlocked); // R6
  AST_FORCE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    force_lock |=> !unlocked); // R5
  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !force_lock) |=> $stable(unlocked)); // R2
  AST_MISMATCH_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !match) |=> !unlocked); // R4
endmodule

// File: rtl/pwg_filter.sv
module pwg_filter
  import pwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  src_e src,
  input  logic prot,
  input  logic unlocked,
  output logic allow
);
  always_comb begin
    if (!valid)                 allow = 1'b0;
    else if (!prot)             allow = 1'b1;
    else if (src == SRC_ONCHIP) allow = 1'b1;
    else                        allow = unlocked;
  end

  AST_TRUSTED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && src == SRC_ONCHIP) |-> allow); // R7
  AST_UNTRUSTED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && prot && src != SRC_ONCHIP && !unlocked) |-> !allow); // R8
  AST_IDLE_NO_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !allow); // R10
endmodule

// File: rtl/pwg_top.sv
module pwg_top
  import pwg_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int KEY_W    = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  pw_i,
  input  logic              key_we,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] key_data,
  input  logic              force_lock,
  input  logic              acc_valid,
  input  logic [1:0]        acc_src,
  input  logic              acc_prot,
  output logic              acc_allow,
  output logic              unlocked_o,
  output logic              perm_lock_o,
  output logic              blank_o
);
  logic [KEY_W-1:0] key_view;
  logic             commit, match, pw_zero, pw_ones, unlocked;

  pwg_keyreg #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(key_we), .wr_idx(key_idx),
    .wr_data(key_data), .key_view(key_view), .commit(commit));

  pwg_compare #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_cmp (
    .pw(pw_i), .key(key_view), .match(match),
    .pw_zero(pw_zero), .pw_ones(pw_ones));

  pwg_lockfsm u_lock (
    .clk(clk), .rst_n(rst_n), .blank(pw_ones), .sealed(pw_zero),
    .commit(commit), .match(match), .force_lock(force_lock),
    .unlocked(unlocked));

  pwg_filter u_filt (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .src(src_e'(acc_src)),
    .prot(acc_prot), .unlocked(unlocked), .allow(acc_allow));

  assign unlocked_o  = unlocked;
  assign perm_lock_o = pw_zero;
  assign blank_o     = pw_ones;

  AST_BLANK_SEALED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(blank_o && perm_lock_o)); // R11
endmodule

// File: tb/sim_pwg_top.sv
module sim_pwg_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pw = '0;
  logic         key_we = 1'b0;
  logic [2:0]   key_idx = '0;
  logic [15:0]  key_data = '0;
  logic         force_lock = 1'b0;
  logic         acc_valid = 1'b0;
  logic [1:0]   acc_src = '0;
  logic         acc_prot = 1'b0;
  logic         acc_allow, unlocked_o, perm_lock_o, blank_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;

  logic [15:0] ref_key [8];
  bit          ref_unl = 0;

  localparam logic [127:0] PW_A = 128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978;

  always #10 clk = ~clk;

  pwg_top u0 (
    .clk(clk), .rst_n(rst_n), .pw_i(pw), .key_we(key_we), .key_idx(key_idx),
    .key_data(key_data), .force_lock(force_lock), .acc_valid(acc_valid),
    .acc_src(acc_src), .acc_prot(acc_prot), .acc_allow(acc_allow),
    .unlocked_o(unlocked_o), .perm_lock_o(perm_lock_o), .blank_o(blank_o));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    bit exp_allow, match;
    logic [15:0] w;
    #2;
    if (!acc_valid)          exp_allow = 0;
    else if (!acc_prot)      exp_allow = 1;
    else if (acc_src == 2'd0) exp_allow = 1;
    else                     exp_allow = ref_unl;
    chk(tag, "acc_allow", acc_allow, exp_allow);
    chk(tag, "unlocked_o", unlocked_o, ref_unl);
    chk(tag, "perm_lock_o", perm_lock_o, pw == '0);
    chk(tag, "blank_o", blank_o, pw == '1);
    @(posedge clk);
    if (!rst_n) begin
      ref_unl = (pw == '1);
      for (int i = 0; i < 8; i++) ref_key[i] = '0;
    end else begin
      match = 1;
      for (int i = 0; i < 8; i++) begin
        w = (key_we && key_idx == 3'(i)) ? key_data : ref_key[i];
        if (w != pw[16*i +: 16]) match = 0;
      end
      if (force_lock) ref_unl = 0;
      else if (key_we && key_idx == 3'd7) ref_unl = match && (pw != '0);
      if (key_we) ref_key[key_idx] = key_data;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [127:0] p, input string tag);
    pw = p; rst_n = 0;
    step(tag); step(tag);
    rst_n = 1;
    step(tag);
  endtask

  task automatic wr(input int idx, input logic [15:0] d, input string tag);
    key_we = 1; key_idx = 3'(idx); key_data = d;
    step(tag);
    key_we = 0;
    step(tag);
  endtask

  task automatic acc(input logic v, input logic [1:0] s, input logic p, input string tag);
    acc_valid = v; acc_src = s; acc_prot = p;
    step(tag);
    acc_valid = 0;
  endtask

  task automatic all_src(input string tag);
    for (int s = 0; s < 4; s++) acc(1, 2'(s), 1, tag);
    acc(1, 2'd1, 0, "R9");
    acc(1, 2'd2, 0, "R9");
    acc(0, 2'd0, 1, "R10");
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_key[i] = '0;
    @(negedge clk);
    do_reset(PW_A, "R1");
    all_src("R8");                                   // R7 on source 0
    // R2: partial key load leaves the flag alone
    for (int i = 0; i < 7; i++) wr(i, PW_A[16*i +: 16], "R2");
    wr(7, PW_A[127:112], "R3");
    all_src("R8");
    // R2 then R4: corrupt word 3 and recommit
    wr(3, 16'hDEAD, "R2");
    wr(7, PW_A[127:112], "R4");
    wr(3, PW_A[63:48], "R2");
    wr(7, PW_A[127:112], "R3");
    // R5: force lock, then force together with a matching commit
    force_lock = 1; step("R5"); force_lock = 0; step("R5");
    wr(7, PW_A[127:112], "R3");
    force_lock = 1; key_we = 1; key_idx = 3'd7; key_data = PW_A[127:112];
    step("R5");
    force_lock = 0; key_we = 0; step("R5");
    // single bit off in word 0
    wr(0, PW_A[15:0] ^ 16'h0001, "R4");
    wr(7, PW_A[127:112], "R4");
    // R1: reset clears the key; committing only word 7 must not open
    do_reset(PW_A, "R1");
    wr(7, PW_A[127:112], "R1");
    // R1 / R11: blank part
    do_reset('1, "R11");
    all_src("R7");
    force_lock = 1; step("R5"); force_lock = 0;
    for (int i = 0; i < 8; i++) wr(i, 16'hFFFF, "R3");
    // R6: sealed part
    do_reset('0, "R6");
    for (int i = 0; i < 8; i++) wr(i, 16'h0000, "R6");
    all_src("R6");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule